// File: doc/BRIEF.md
# Pulse-Race Frequency and On-Time Modulator

This block drives the high-side switch of a buck converter that runs in discontinuous conduction mode, and gives the rest of the control loop its low-rate clock. Two 5-bit commands steer it. The on-time command sets how long the switch conducts, and so the peak inductor current. The frequency command sets how slowly a leading edge crawls around a ring of set/clear stages. Each delay cell is one tick of the fast clock, so the whole block is synchronous logic.

Every switching cycle begins with a one-tick start strobe, and both commands are captured on that strobe. A tapped chain of delay cells ends the gate pulse. A second tapped chain launches a fast trailing edge into a ring of 32 stage latches. A slower leading edge, released at the strobe, sets each latch it reaches. The trailing edge clears each latch it reaches. When the trailing edge has caught the leading edge, every latch reads low. The block then declares end of race and issues the next strobe. In this way a long period comes from fast cells instead of from a wide period counter. The loop clock falls at end of race and rises again right after the strobe, so the controller steps once per switching period.

Top module: `pulse_race_modulator`

## Requirements
- R1: While reset is held, `cyc_start`, `gate_drv` and `sys_clk` are low. In the first cycle after reset is released, `cyc_start` is high, which starts the first switching cycle.
- R2: `cyc_start` is high for exactly one cycle per switching period.
- R3: `gate_drv` is low in the cycle where `cyc_start` is high, and it is high in the cycle after.
- R4: `gate_drv` stays high for exactly `ton_cmd`+1 cycles. It is high in cycles 1 to `ton_cmd`+1 after the strobe and low for the rest of the period.
- R5: The block uses `ton_cmd` and `frq_cmd` only in the cycle where `cyc_start` is high. Changing them at any other time has no effect on the gate width or the period in progress.
- R6: Let t be the captured on-time command, f the captured frequency command and H = f+2. The leading edge has advanced m − ceil(m/H) stages m ticks after the strobe. The trailing edge leaves t+1 ticks after the strobe and moves one stage per tick. The period is t+k+3 cycles, where k is the smallest k ≥ 0 with k ≥ (1+t+k) − ceil((1+t+k)/H).
- R7: After the first strobe, `sys_clk` is low only in the strobe cycles and high in every other cycle. Before the first strobe it is low.
- R8: A command of 0 gives the minimum one-cell delay. With `ton_cmd`=0 the gate is one cycle wide. With both commands at 0 the period is 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one tick is one delay cell |
| rst | input | 1 | Synchronous reset, active high |
| ton_cmd | input | CMD_W | On-time command, captured at the strobe |
| frq_cmd | input | CMD_W | Frequency command (leading-edge stage delay), captured at the strobe |
| gate_drv | output | 1 | High-side switch gate |
| sys_clk | output | 1 | Low-rate clock for the control loop |
| cyc_start | output | 1 | One-cycle strobe that opens each switching cycle |

## Verification
The assertions take for granted that reset is synchronous and held for at least one edge, and that both commands always carry defined values. They make no assumption about when the commands change. The stimulus drives every input away from the clock edge. It places each planned command pair in the strobe cycle and, on alternate periods, drives arbitrary values in all other cycles, so that capture at the strobe alone is exercised. The command sweep covers every on-time against the slowest, fastest and next-to-fastest frequency settings, and every frequency against the extreme on-times, followed by random pairs.

// File: rtl/pr_mod_pkg.sv
package pr_mod_pkg;
   // default command width and ring size of the block
   localparam int unsigned PR_CMD_W_DEF = 5;
   localparam int unsigned PR_RING_DEF  = 32;

   // which of the two tap chains a delay line instance plays
   typedef enum logic [0:0] {
      LINE_ONTIME = 1'b0,
      LINE_RACE   = 1'b1
   } line_role_e;
endpackage

// File: rtl/pr_delay_line.sv
module pr_delay_line #(
   parameter int unsigned CMD_W = 5,
   parameter pr_mod_pkg::line_role_e ROLE = pr_mod_pkg::LINE_ONTIME
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             flush,
   input  logic [CMD_W-1:0] sel,
   output logic             tap
);
   localparam int unsigned CELLS = 2 ** CMD_W;

   logic [CELLS-1:0] cell_q;

   // the first cell takes the start strobe; the strobe also empties the rest
   always_ff @(posedge clk) begin
      if (rst) cell_q[0] <= 1'b0;
      else     cell_q[0] <= flush;
   end

   for (genvar i = 1; i < CELLS; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (rst || flush) cell_q[i] <= 1'b0;
         else              cell_q[i] <= cell_q[i-1];
      end
   end

   assign tap = cell_q[sel];

   // R4
   cells_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cell_q))
      else $error("delay line %0d holds more than one pulse", ROLE);
endmodule

// File: rtl/pr_stage_pacer.sv
module pr_stage_pacer #(
   parameter int unsigned CMD_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             run,
   input  logic [CMD_W-1:0] frq,
   output logic             step
);
   localparam int unsigned CW = CMD_W + 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   // a pacing cycle is frq+2 ticks: one idle tick, then frq+1 advancing ticks
   assign limit = {1'b0, frq} + CW'(1);
   assign step  = run && (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (rst || start)  cnt_q <= '0;
      else if (run)      cnt_q <= (cnt_q == limit) ? '0 : cnt_q + CW'(1);
   end

   // R6
   pace_range_chk: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt_q <= limit))
      else $error("stage pacer count beyond its window");
endmodule

// File: rtl/pr_race_ring.sv
module pr_race_ring #(
   parameter int unsigned CMD_W  = 5,
   parameter int unsigned STAGES = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             launch,
   input  logic [CMD_W-1:0] frq,
   output logic             race_done
);
   localparam int unsigned RW = $clog2(STAGES);
   localparam logic [RW-1:0] LAST = RW'(STAGES - 1);

   logic [STAGES-1:0] latch_q, set_m, clr_m;
   logic [RW-1:0]     lead_q, trail_q, lead_nxt, trail_nxt;
   logic              racing_q, trail_on_q, step, fire;

   pr_stage_pacer #(.CMD_W(CMD_W)) u_pacer (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .run   (racing_q),
      .frq   (frq),
      .step  (step)
   );

   assign lead_nxt  = (lead_q  == LAST) ? '0 : lead_q  + RW'(1);
   assign trail_nxt = (trail_q == LAST) ? '0 : trail_q + RW'(1);
   assign fire      = racing_q && launch && !trail_on_q;

   // leading edge sets, trailing edge clears; clearing wins on the same stage
   always_comb begin
      set_m = '0;
      clr_m = '0;
      if (racing_q && step) set_m[lead_nxt] = 1'b1;
      if (fire)                          clr_m[0]         = 1'b1;
      else if (racing_q && trail_on_q)   clr_m[trail_nxt] = 1'b1;
   end

   assign race_done = racing_q && trail_on_q && (latch_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         latch_q    <= '0;
         lead_q     <= '0;
         trail_q    <= '0;
         racing_q   <= 1'b0;
         trail_on_q <= 1'b0;
      end else if (start) begin
         latch_q    <= {{(STAGES-1){1'b0}}, 1'b1};
         lead_q     <= '0;
         trail_q    <= '0;
         racing_q   <= 1'b1;
         trail_on_q <= 1'b0;
      end else begin
         latch_q <= (latch_q | set_m) & ~clr_m;
         if (racing_q && step) lead_q <= lead_nxt;
         if (fire) begin
            trail_on_q <= 1'b1;
            trail_q    <= '0;
         end else if (racing_q && trail_on_q) begin
            trail_q <= trail_nxt;
         end
         if (race_done) racing_q <= 1'b0;
      end
   end

   // R6
   live_latch_chk: assert property (@(posedge clk) disable iff (rst)
      (racing_q && !trail_on_q) |-> (latch_q != '0))
      else $error("ring emptied before the trailing edge left");

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      race_done |=> !race_done)
      else $error("end of race held for two cycles");
endmodule

// File: rtl/pulse_race_modulator.sv
module pulse_race_modulator #(
   parameter int unsigned CMD_W       = pr_mod_pkg::PR_CMD_W_DEF,
   parameter int unsigned RING_STAGES = pr_mod_pkg::PR_RING_DEF,
   parameter bit          SHARE_CHAIN = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CMD_W-1:0] ton_cmd,
   input  logic [CMD_W-1:0] frq_cmd,
   output logic             gate_drv,
   output logic             sys_clk,
   output logic             cyc_start
);
   localparam int unsigned TAPS = 2 ** CMD_W;

   if (CMD_W < 1 || CMD_W > 8) begin : g_bad_width
      $error("CMD_W must lie in 1..8");
   end
   if (RING_STAGES < TAPS || RING_STAGES < 2) begin : g_bad_ring
      $error("ring needs at least as many stages as delay taps");
   end

   logic             boot_q, trig_q, gate_q, sysclk_q;
   logic [CMD_W-1:0] ton_l, frq_l;
   logic             tap_a, tap_b, eor;

   if (SHARE_CHAIN) begin : g_shared
      pr_delay_line #(.CMD_W(CMD_W), .ROLE(pr_mod_pkg::LINE_ONTIME)) u_line (
         .clk (clk), .rst (rst), .flush (trig_q), .sel (ton_l), .tap (tap_a)
      );
      assign tap_b = tap_a;
   end else begin : g_split
      pr_delay_line #(.CMD_W(CMD_W), .ROLE(pr_mod_pkg::LINE_ONTIME)) u_on_line (
         .clk (clk), .rst (rst), .flush (trig_q), .sel (ton_l), .tap (tap_a)
      );
      pr_delay_line #(.CMD_W(CMD_W), .ROLE(pr_mod_pkg::LINE_RACE)) u_race_line (
         .clk (clk), .rst (rst), .flush (trig_q), .sel (ton_l), .tap (tap_b)
      );
   end

   pr_race_ring #(.CMD_W(CMD_W), .STAGES(RING_STAGES)) u_ring (
      .clk       (clk),
      .rst       (rst),
      .start     (trig_q),
      .launch    (tap_b),
      .frq       (frq_l),
      .race_done (eor)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         boot_q   <= 1'b1;
         trig_q   <= 1'b0;
         gate_q   <= 1'b0;
         sysclk_q <= 1'b0;
         ton_l    <= '0;
         frq_l    <= '0;
      end else begin
         boot_q <= 1'b0;
         trig_q <= boot_q | eor;
         if (trig_q) begin
            ton_l    <= ton_cmd;
            frq_l    <= frq_cmd;
            gate_q   <= 1'b1;
            sysclk_q <= 1'b1;
         end else begin
            if (tap_a) gate_q   <= 1'b0;
            if (eor)   sysclk_q <= 1'b0;
         end
      end
   end

   assign gate_drv  = gate_q;
   assign sys_clk   = sysclk_q;
   assign cyc_start = trig_q;

   // R2
   start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      cyc_start |=> !cyc_start)
      else $error("start strobe wider than one cycle");

   // R3
   gate_open_chk: assert property (@(posedge clk) disable iff (rst)
      cyc_start |=> gate_drv)
      else $error("gate did not open after the strobe");

   // R3
   gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
      cyc_start |-> !gate_drv)
      else $error("gate still high when the next cycle starts");

   // R7
   clk_low_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(sys_clk) |-> cyc_start)
      else $error("loop clock fell outside a strobe");

   // R7
   clk_excl_chk: assert property (@(posedge clk) disable iff (rst)
      sys_clk |-> !cyc_start)
      else $error("loop clock high during a strobe");
endmodule

// File: tb/pulse_race_modulator_tb.sv
module pulse_race_modulator_tb_top;
   localparam int CMD_W = 5;
   localparam int WATCH = 150000;

   logic             clk = 1'b0;
   logic             rst;
   logic [CMD_W-1:0] ton_cmd, frq_cmd;
   logic             gate_drv, sys_clk, cyc_start;

   int vectors = 0;
   int fails   = 0;
   bit fin     = 1'b0;

   int q_ton[$];
   int q_frq[$];

   always #4 clk = ~clk;

   pulse_race_modulator dut_i (
      .clk       (clk),
      .rst       (rst),
      .ton_cmd   (ton_cmd),
      .frq_cmd   (frq_cmd),
      .gate_drv  (gate_drv),
      .sys_clk   (sys_clk),
      .cyc_start (cyc_start)
   );

   // period from R6: leading edge m - ceil(m/H), trailing edge one stage per tick
   function automatic int race_period(input int t, input int f);
      int h = f + 2;
      for (int k = 0; k < 8192; k++) begin
         int m  = 1 + t + k;
         int dl = m - (m + h - 1) / h;
         if (k >= dl) return t + k + 3;
      end
      return -1;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      int    age, per, idx, tl, fl;
      bit    junk, first;
      bit    e_start, e_gate, e_clk;
      string tag;

      rst = 1'b1;
      ton_cmd = '0;
      frq_cmd = '0;
      for (int t = 0; t < 32; t++) begin
         q_ton.push_back(t); q_frq.push_back(0);
         q_ton.push_back(t); q_frq.push_back(1);
         q_ton.push_back(t); q_frq.push_back(31);
      end
      for (int f = 0; f < 32; f++) begin
         q_ton.push_back(0);  q_frq.push_back(f);
         q_ton.push_back(31); q_frq.push_back(f);
      end
      for (int r = 0; r < 40; r++) begin
         q_ton.push_back(int'($urandom_range(0, 31)));
         q_frq.push_back(int'($urandom_range(0, 31)));
      end

      // R1: outputs quiet under reset
      repeat (3) begin
         @(negedge clk);
         chk(cyc_start == 1'b0, "R1 strobe under reset", int'(cyc_start), 0);
         chk(gate_drv  == 1'b0, "R1 gate under reset",   int'(gate_drv),  0);
         chk(sys_clk   == 1'b0, "R1 clock under reset",  int'(sys_clk),   0);
      end
      rst   = 1'b0;
      age   = -1;
      per   = 0;
      idx   = 0;
      tl    = 0;
      fl    = 0;
      junk  = 1'b0;
      first = 1'b1;

      while (!fin) begin
         @(negedge clk);
         if (age < 0) age = 0;
         else begin
            age++;
            if (age == per) age = 0;
         end
         e_start = (age == 0);
         e_gate  = (age >= 1) && (age <= tl + 1);
         e_clk   = (age != 0);

         if (first)                   tag = "R1 first strobe";
         else if (age == 1)           tag = "R2 strobe width";
         else if (tl == 0 && fl == 0) tag = "R8 minimum period";
         else                         tag = "R6 race period";
         chk(cyc_start == e_start, tag, int'(cyc_start), int'(e_start));

         if (first)          tag = "R1 gate before first cycle";
         else if (age <= 1)  tag = "R3 gate edge at strobe";
         else if (junk)      tag = "R5 gate with moving command";
         else if (tl == 0)   tag = "R8 minimum gate";
         else                tag = "R4 gate width";
         chk(gate_drv == e_gate, tag, int'(gate_drv), int'(e_gate));

         chk(sys_clk == e_clk, first ? "R1 clock before first cycle" : "R7 loop clock",
             int'(sys_clk), int'(e_clk));
         first = 1'b0;

         if (age == 0) begin
            if (idx == q_ton.size()) fin = 1'b1;
            else begin
               tl      = q_ton[idx];
               fl      = q_frq[idx];
               ton_cmd = CMD_W'(tl);
               frq_cmd = CMD_W'(fl);
               per     = race_period(tl, fl);
               junk    = (idx % 2) == 1;
               idx++;
            end
         end else if (junk) begin
            ton_cmd = CMD_W'($urandom);
            frq_cmd = CMD_W'($urandom);
         end
      end
      summary();
      $finish;
   end

   initial begin
      repeat (WATCH) @(posedge clk);
      if (!fin) begin
         fails++;
         $display("FAIL R6 watchdog expired: got 0 expected 1 completed run");
         summary();
         $finish;
      end
   end
endmodule